// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks line reservations for paired load-linked and store-conditional operations. It sits beside a data cache's completion path. Each completed write-class operation arrives as a single-cycle event carrying an operation code, a line address and the version ID of the requester. The monitor updates a small table of reservation entries. One cycle later it returns a one-bit result with a valid strobe.

A load-linked claims its line for its version. A later store-conditional from the same version succeeds only if that claim is still intact. Every store-conditional consumes the reservation on its line, whether it succeeds or fails. An ordinary store from the owning version quietly drops the reservation. When the table is full, a load-linked to a new line evicts entries in round-robin order. A bypass input turns the whole mechanism off for the events it accompanies.

Top module: `rsv_monitor`

## Requirements
- R1: After reset the table holds no reservations and `res_valid` and `res_ok` are 0; a store-conditional issued after reset fails even if its line was reserved before reset.
- R2: `res_valid` is 1 in exactly the cycle after each cycle in which `evt_valid` is 1, and 0 otherwise.
- R3: Operation codes on `evt_op` are: 2'b00 ordinary store, 2'b01 load-linked, 2'b10 store-conditional, 2'b11 other (no effect on reservations). A load-linked always reports `res_ok`=1 and reserves its line for `evt_ver`.
- R4: A store-conditional reports `res_ok`=1 only when its line holds a reservation tagged with the same version; otherwise it reports 0.
- R5: Every store-conditional that is not bypassed removes the reservation on its line, whatever the version and whatever the result.
- R6: An ordinary store removes the reservation on its line only when that reservation carries the store's own version; a store from another version leaves it in place.
- R7: Ordinary stores and other operations always report `res_ok`=1.
- R8: When `bypass` is 1 with an event, the result is `res_ok`=1 and the reservation table is left unchanged.
- R9: A line holds at most one entry; a load-linked to a line already reserved retags that entry with the new version.
- R10: A load-linked to a new line fills the lowest-numbered free entry. When no entry is free, it replaces the entry at a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, on each replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Completion event present this cycle |
| evt_op | input | 2 | Operation code (see R3) |
| evt_line | input | LINE_W (16) | Line address of the operation |
| evt_ver | input | VER_W (4) | Requester version ID |
| bypass | input | 1 | Skip reservation handling, report success |
| res_valid | output | 1 | Result strobe, one cycle after the event |
| res_ok | output | 1 | Result: 1 success, 0 failed store-conditional |

## Verification
The hardest state to reach from the ports is the full table with the round-robin pointer away from entry 0. Reaching it takes a run of load-linked operations to distinct lines, then a replacement, then a store-conditional that frees a slot. That sequence shows the free slot is preferred over the pointer. The stimulus reaches this state from a fresh reset with a fixed sequence of seven lines. It reads the table's contents back only through the pass or fail of store-conditionals. Each probe is ordered so that the entry it clears does not disturb the later probes.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    OP_STORE = 2'b00,
    OP_LINK  = 2'b01,
    OP_COND  = 2'b10,
    OP_OTHER = 2'b11
  } rsv_op_e;
endpackage

// File: rtl/rsv_lookup.sv
module rsv_lookup #(
  parameter int N      = 4,
  parameter int LINE_W = 16,
  parameter int VER_W  = 4
) (
  input  logic [N-1:0]             ent_vld,
  input  logic [N-1:0][LINE_W-1:0] ent_line,
  input  logic [N-1:0][VER_W-1:0]  ent_ver,
  input  logic [LINE_W-1:0]        q_line,
  input  logic [VER_W-1:0]         q_ver,
  output logic [N-1:0]             line_hit,
  output logic [N-1:0]             own_hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign line_hit[i] = ent_vld[i] && (ent_line[i] == q_line);
    assign own_hit[i]  = line_hit[i] && (ent_ver[i] == q_ver);
  end
endmodule

// File: rtl/rsv_victim.sv
module rsv_victim #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     ent_vld,
  input  logic             adv,
  output logic [IDX_W-1:0] slot,
  output logic             full
);
  logic [IDX_W-1:0] rr_q;

  function automatic logic [IDX_W-1:0] lowest_free(input logic [N-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!v[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [IDX_W-1:0] step_ptr(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(N - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full = &ent_vld;
  assign slot = full ? rr_q : lowest_free(ent_vld);

  always_ff @(posedge clk) begin
    if (!rst_n) rr_q <= '0;
    else if (adv) rr_q <= step_ptr(rr_q);
  end

  // R10
  adv_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> full);
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor #(
  parameter int NUM_ENTRIES = 4,
  parameter int LINE_W      = 16,
  parameter int VER_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [1:0]        evt_op,
  input  logic [LINE_W-1:0] evt_line,
  input  logic [VER_W-1:0]  evt_ver,
  input  logic              bypass,
  output logic              res_valid,
  output logic              res_ok
);
  import rsv_pkg::*;
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0]             ent_vld;
  logic [NUM_ENTRIES-1:0][LINE_W-1:0] ent_line;
  logic [NUM_ENTRIES-1:0][VER_W-1:0]  ent_ver;
  logic [NUM_ENTRIES-1:0]             line_hit, own_hit;
  logic [IDX_W-1:0]                   slot;
  logic                               full;

  rsv_op_e op;
  logic    act, is_link, is_cond, is_store;
  logic    any_line_hit, any_own_hit, alloc_new, replace_en, ok_d;

  assign op       = rsv_op_e'(evt_op);
  assign act      = evt_valid && !bypass;
  assign is_link  = (op == OP_LINK);
  assign is_cond  = (op == OP_COND);
  assign is_store = (op == OP_STORE);

  rsv_lookup #(.N(NUM_ENTRIES), .LINE_W(LINE_W), .VER_W(VER_W)) u_lookup (
    .ent_vld (ent_vld),
    .ent_line(ent_line),
    .ent_ver (ent_ver),
    .q_line  (evt_line),
    .q_ver   (evt_ver),
    .line_hit(line_hit),
    .own_hit (own_hit)
  );

  assign any_line_hit = |line_hit;
  assign any_own_hit  = |own_hit;
  assign alloc_new    = act && is_link && !any_line_hit;
  assign replace_en   = alloc_new && full;

  rsv_victim #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk    (clk),
    .rst_n  (rst_n),
    .ent_vld(ent_vld),
    .adv    (replace_en),
    .slot   (slot),
    .full   (full)
  );

  // Result: only a live store-conditional can report failure.
  assign ok_d = (act && is_cond) ? any_own_hit : 1'b1;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic clr_i, tag_i;
    assign clr_i = act && ((is_cond && line_hit[i]) || (is_store && own_hit[i]));
    assign tag_i = act && is_link &&
                   (line_hit[i] || (alloc_new && (slot == IDX_W'(i))));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_vld[i]  <= 1'b0;
        ent_line[i] <= '0;
        ent_ver[i]  <= '0;
      end else if (tag_i) begin
        ent_vld[i]  <= 1'b1;
        ent_line[i] <= evt_line;
        ent_ver[i]  <= evt_ver;
      end else if (clr_i) begin
        ent_vld[i]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
    end else begin
      res_valid <= evt_valid;
      res_ok    <= evt_valid ? ok_d : 1'b0;
    end
  end

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> res_valid);
  // R2
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> !res_valid);
  // R7
  non_cond_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !is_cond) |=> res_ok);
  // R4
  cond_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && is_cond && !any_own_hit) |=> !res_ok);
  // R5
  cond_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && is_cond) |=> ((ent_vld & $past(line_hit)) == '0));
  // R8
  bypass_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && bypass) |=> (res_ok && $stable(ent_vld)));
  // R9
  single_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_hit));
endmodule

// File: tb/rsv_monitor_bench.sv
`timescale 1ns/1ps
module rsv_monitor_bench;
  import rsv_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid;
  logic [1:0]  evt_op;
  logic [15:0] evt_line;
  logic [3:0]  evt_ver;
  logic        bypass;
  logic        res_valid, res_ok;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rsv_monitor u_rsv_monitor (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_op(evt_op),
    .evt_line(evt_line), .evt_ver(evt_ver), .bypass(bypass),
    .res_valid(res_valid), .res_ok(res_ok)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] line;
    logic [3:0]  ver;
    logic        byp;
    logic        exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{OP_LINK,  16'd10, 4'd1, 1'b0, 1'b1, 8'd3},  // R3
    '{OP_COND,  16'd10, 4'd2, 1'b0, 1'b0, 8'd4},  // R4 wrong version
    '{OP_COND,  16'd10, 4'd1, 1'b0, 1'b0, 8'd5},  // R5 cleared by failed SC
    '{OP_LINK,  16'd10, 4'd1, 1'b0, 1'b1, 8'd3},
    '{OP_COND,  16'd10, 4'd1, 1'b0, 1'b1, 8'd4},  // R4 success
    '{OP_COND,  16'd10, 4'd1, 1'b0, 1'b0, 8'd5},  // R5 cleared by good SC
    '{OP_COND,  16'd77, 4'd1, 1'b0, 1'b0, 8'd4},  // never reserved
    '{OP_LINK,  16'd20, 4'd3, 1'b0, 1'b1, 8'd3},
    '{OP_STORE, 16'd20, 4'd4, 1'b0, 1'b1, 8'd7},  // R7
    '{OP_COND,  16'd20, 4'd3, 1'b0, 1'b1, 8'd6},  // R6 foreign store kept it
    '{OP_LINK,  16'd30, 4'd5, 1'b0, 1'b1, 8'd3},
    '{OP_STORE, 16'd30, 4'd5, 1'b0, 1'b1, 8'd7},
    '{OP_COND,  16'd30, 4'd5, 1'b0, 1'b0, 8'd6},  // R6 own store cleared
    '{OP_LINK,  16'd40, 4'd1, 1'b0, 1'b1, 8'd9},  // R9
    '{OP_LINK,  16'd40, 4'd2, 1'b0, 1'b1, 8'd9},
    '{OP_COND,  16'd40, 4'd1, 1'b0, 1'b0, 8'd9},  // retagged away from v1
    '{OP_COND,  16'd40, 4'd2, 1'b0, 1'b0, 8'd5},
    '{OP_LINK,  16'd41, 4'd1, 1'b0, 1'b1, 8'd3},
    '{OP_LINK,  16'd41, 4'd2, 1'b0, 1'b1, 8'd9},
    '{OP_COND,  16'd41, 4'd2, 1'b0, 1'b1, 8'd9},
    '{OP_OTHER, 16'd50, 4'd1, 1'b0, 1'b1, 8'd7},
    '{OP_LINK,  16'd60, 4'd1, 1'b1, 1'b1, 8'd8},  // R8
    '{OP_COND,  16'd60, 4'd1, 1'b0, 1'b0, 8'd8},  // bypassed LL set nothing
    '{OP_LINK,  16'd61, 4'd1, 1'b0, 1'b1, 8'd3},
    '{OP_COND,  16'd61, 4'd1, 1'b1, 1'b1, 8'd8},
    '{OP_COND,  16'd61, 4'd1, 1'b0, 1'b1, 8'd8},  // bypassed SC cleared nothing
    '{OP_COND,  16'd99, 4'd1, 1'b1, 1'b1, 8'd8}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [15:0] line,
                        input logic [3:0] ver, input logic byp,
                        input logic exp, input string tag);
    @(negedge clk);
    evt_valid = 1'b1; evt_op = op; evt_line = line; evt_ver = ver; bypass = byp;
    @(negedge clk);
    evt_valid = 1'b0; bypass = 1'b0;
    check({tag, " strobe"}, res_valid, 1'b1);
    check(tag, res_ok, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_all();
    do_reset();
    check("R1 res_valid", res_valid, 1'b0);
    check("R1 res_ok", res_ok, 1'b0);

    for (int k = 0; k < NV; k++) begin
      run_op(VECS[k].op, VECS[k].line, VECS[k].ver, VECS[k].byp,
             VECS[k].exp, $sformatf("R%0d vec%0d", VECS[k].req, k));
    end

    // R2: idle cycle drops the strobe
    @(negedge clk);
    check("R2 idle", res_valid, 1'b0);

    // R1: reservation lost across reset
    run_op(OP_LINK, 16'd70, 4'd1, 1'b0, 1'b1, "R3 pre-reset");
    do_reset();
    run_op(OP_COND, 16'd70, 4'd1, 1'b0, 1'b0, "R1 after reset");

    // R10: fill, replace round-robin, free slot preferred over pointer
    do_reset();
    for (int k = 0; k < 4; k++)
      run_op(OP_LINK, 16'(100 + k), 4'd2, 1'b0, 1'b1, "R10 fill");
    run_op(OP_LINK, 16'd104, 4'd2, 1'b0, 1'b1, "R10 replace0");
    run_op(OP_COND, 16'd100, 4'd2, 1'b0, 1'b0, "R10 evicted0");
    run_op(OP_LINK, 16'd105, 4'd2, 1'b0, 1'b1, "R10 replace1");
    run_op(OP_COND, 16'd101, 4'd2, 1'b0, 1'b0, "R10 evicted1");
    run_op(OP_COND, 16'd102, 4'd2, 1'b0, 1'b1, "R10 kept2");
    run_op(OP_LINK, 16'd106, 4'd2, 1'b0, 1'b1, "R10 into free");
    run_op(OP_COND, 16'd103, 4'd2, 1'b0, 1'b1, "R10 kept3");
    run_op(OP_COND, 16'd104, 4'd2, 1'b0, 1'b1, "R10 kept4");
    run_op(OP_COND, 16'd105, 4'd2, 1'b0, 1'b1, "R10 kept5");
    run_op(OP_COND, 16'd106, 4'd2, 1'b0, 1'b1, "R10 kept6");
  endtask

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; evt_op = 2'b00;
    evt_line = '0; evt_ver = '0; bypass = 1'b0;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule